// File: doc/BRIEF.md
# Two-Pin PWM Channel with Complementary and Push-Pull Modes

This block is a single pulse-width modulation channel that drives a pair of output pins, A and B, from one period counter and one duty setting. In complementary mode the B pin carries the logical inverse of A at every cycle. In push-pull mode both pins use the same active level and the same pulse width. The pulse moves to the other pin at each period, so A and B take turns. Each pin then pulses once every two periods. A half-bridge driver is the typical consumer of push-pull operation.

Software-side logic programs the channel through a synchronous write port. A select code picks the field: period, duty, polarity, mode or enable. The period, duty, polarity and mode fields are staged. The running channel adopts them only at the end of the current period, so the waveform never changes in the middle of a period. A one-cycle strobe marks the first cycle of every period.

Top module: `pwm_dual_out`

## Requirements
- R1: After reset the channel is disabled, in complementary mode, with active-high polarity, a staged period of RST_PERIOD and a duty of 0. Both pins are low and the strobe is low.
- R2: When enabled in complementary mode (mode value 0), pin A is at the active level for the first `duty` cycles of each period and at the inactive level for the rest. Pin B is the inverse of A in every cycle.
- R3: When enabled in push-pull mode (mode value 1), periods alternate, starting with A after enable. In its period, the pin that owns the pulse is active for the first `duty` cycles. The other pin stays inactive for the whole period. Both pins use the same active level.
- R4: With period value P, a period lasts P+1 cycles. `period_start` is high for exactly the first cycle of each period while enabled, and low while disabled.
- R5: Writes to period, duty, polarity or mode take effect at the clock edge that ends the current period. While the channel is disabled, they take effect on the edge after the write.
- R6: A duty of 0 keeps the pulse-carrying pin inactive for the whole period.
- R7: A duty equal to or greater than the period length P+1 keeps the pulse-carrying pin active for the whole period.
- R8: While disabled, both pins sit at the inactive level and the counter and phase are cleared. The first period after enabling starts at once with the strobe, and in push-pull mode that period goes to pin A.
- R9: Polarity value 1 makes the active level high. Polarity value 0 makes it low, and the inactive level is then high.
- R10: Write selects are: 0 sets the period, 1 sets the duty, 2 sets the polarity (bit 0), 3 sets the mode (bit 0) and 4 sets the enable (bit 0). Selects 5 to 7 are ignored. The enable takes effect on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | CW | Write value (fields of one bit use bit 0) |
| pwm_a | output | 1 | Output pin A |
| pwm_b | output | 1 | Output pin B |
| period_start | output | 1 | One-cycle strobe in the first cycle of every period |

## Verification
The bench builds the channel with a 6-bit counter (CW=6) and RST_PERIOD=7. With these values, short periods of a handful of cycles keep many push-pull alternations within a few thousand cycles. Random duty values up to 20 then fall both below and at or above the period length, so the full-on case R7 occurs often. A duty of 0 occurs as well. The random stream also issues writes at every point within a period. This exercises the staging rule R5 when a write lands on the wrap cycle itself.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  typedef enum logic {
    MODE_COMP     = 1'b0,
    MODE_PUSHPULL = 1'b1
  } pwm_mode_e;

  localparam int unsigned SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_PERIOD = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DUTY   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_POL    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MODE   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_EN     = 3'd4;
endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow
  import pwm_dual_pkg::*;
#(
  parameter int unsigned CW         = 8,
  parameter int unsigned RST_PERIOD = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CW-1:0]    wr_data,
  input  logic             wrap_i,
  output logic             run_o,
  output logic [CW-1:0]    per_o,
  output logic [CW-1:0]    duty_o,
  output logic             pol_o,
  output pwm_mode_e        mode_o
);
  localparam logic [CW-1:0] PER_RST = CW'(RST_PERIOD);

  // staged copies written by the port
  logic [CW-1:0] stg_per_q,  stg_per_d;
  logic [CW-1:0] stg_duty_q, stg_duty_d;
  logic          stg_pol_q,  stg_pol_d;
  pwm_mode_e     stg_mode_q, stg_mode_d;
  logic          run_q,      run_d;
  // active copies used by the waveform
  logic [CW-1:0] act_per_q,  act_per_d;
  logic [CW-1:0] act_duty_q, act_duty_d;
  logic          act_pol_q,  act_pol_d;
  pwm_mode_e     act_mode_q, act_mode_d;
  logic          load_act;

  always_comb begin
    stg_per_d  = stg_per_q;
    stg_duty_d = stg_duty_q;
    stg_pol_d  = stg_pol_q;
    stg_mode_d = stg_mode_q;
    run_d      = run_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_PERIOD: stg_per_d  = wr_data;
        SEL_DUTY:   stg_duty_d = wr_data;
        SEL_POL:    stg_pol_d  = wr_data[0];
        SEL_MODE:   stg_mode_d = pwm_mode_e'(wr_data[0]);
        SEL_EN:     run_d      = wr_data[0];
        default: ;
      endcase
    end
  end

  assign load_act = !run_q || wrap_i;

  always_comb begin
    act_per_d  = act_per_q;
    act_duty_d = act_duty_q;
    act_pol_d  = act_pol_q;
    act_mode_d = act_mode_q;
    if (load_act) begin
      act_per_d  = stg_per_q;
      act_duty_d = stg_duty_q;
      act_pol_d  = stg_pol_q;
      act_mode_d = stg_mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_per_q  <= PER_RST;
      stg_duty_q <= '0;
      stg_pol_q  <= 1'b1;
      stg_mode_q <= MODE_COMP;
      run_q      <= 1'b0;
      act_per_q  <= PER_RST;
      act_duty_q <= '0;
      act_pol_q  <= 1'b1;
      act_mode_q <= MODE_COMP;
    end else begin
      stg_per_q  <= stg_per_d;
      stg_duty_q <= stg_duty_d;
      stg_pol_q  <= stg_pol_d;
      stg_mode_q <= stg_mode_d;
      run_q      <= run_d;
      act_per_q  <= act_per_d;
      act_duty_q <= act_duty_d;
      act_pol_q  <= act_pol_d;
      act_mode_q <= act_mode_d;
    end
  end

  assign run_o  = run_q;
  assign per_o  = act_per_q;
  assign duty_o = act_duty_q;
  assign pol_o  = act_pol_q;
  assign mode_o = act_mode_q;

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap_i) |=> ($stable(act_per_q) && $stable(act_duty_q) &&
                            $stable(act_pol_q) && $stable(act_mode_q)));
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          phase_o,
  output logic          wrap_o,
  output logic          start_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          at_end;

  assign at_end = (cnt_q == per_i);

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run_i) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (at_end) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
    end else begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
  assign wrap_o  = run_i && at_end;
  assign start_o = run_i && (cnt_q == '0);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i)) |-> (cnt_q <= $past(per_i)) || (cnt_q == '0));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !at_end) |=> $stable(phase_q));

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && !phase_q));
endmodule

// File: rtl/pwm_out_steer.sv
module pwm_out_steer
  import pwm_dual_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          phase_i,
  input  logic [CW-1:0] duty_i,
  input  logic          pol_i,
  input  pwm_mode_e     mode_i,
  output logic          out_a,
  output logic          out_b
);
  logic pulse;
  logic idle_lvl;

  assign pulse    = (cnt_i < duty_i);
  assign idle_lvl = ~pol_i;

  always_comb begin
    out_a = idle_lvl;
    out_b = idle_lvl;
    if (run_i) begin
      if (mode_i == MODE_COMP) begin
        out_a = pulse ? pol_i : idle_lvl;
        out_b = ~out_a;
      end else begin
        out_a = (pulse && !phase_i) ? pol_i : idle_lvl;
        out_b = (pulse &&  phase_i) ? pol_i : idle_lvl;
      end
    end
  end

  // R3
  pp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == MODE_PUSHPULL) |-> !(out_a == pol_i && out_b == pol_i));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (out_a == ~pol_i && out_b == ~pol_i));

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && duty_i == '0) |-> (out_a == ~pol_i || mode_i == MODE_COMP));
endmodule

// File: rtl/pwm_dual_out.sv
module pwm_dual_out
  import pwm_dual_pkg::*;
#(
  parameter int unsigned CW         = 8,
  parameter int unsigned RST_PERIOD = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CW-1:0]    wr_data,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             period_start
);
  logic          rst_meta_q, rst_sync_q;
  logic          run;
  logic [CW-1:0] per, duty, cnt;
  logic          pol, phase, wrap;
  pwm_mode_e     mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pwm_cfg_shadow #(.CW(CW), .RST_PERIOD(RST_PERIOD)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .wrap_i (wrap),
    .run_o  (run),
    .per_o  (per),
    .duty_o (duty),
    .pol_o  (pol),
    .mode_o (mode)
  );

  pwm_period_ctr #(.CW(CW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .run_i  (run),
    .per_i  (per),
    .cnt_o  (cnt),
    .phase_o(phase),
    .wrap_o (wrap),
    .start_o(period_start)
  );

  pwm_out_steer #(.CW(CW)) u_out (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .run_i  (run),
    .cnt_i  (cnt),
    .phase_i(phase),
    .duty_i (duty),
    .pol_i  (pol),
    .mode_i (mode),
    .out_a  (pwm_a),
    .out_b  (pwm_b)
  );

  // R2
  comp_inverse_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (run && mode == MODE_COMP) |-> (pwm_b != pwm_a));

  // R4
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !run |-> !period_start);
endmodule

// File: tb/tb_pwm_dual_out.sv
`timescale 1ns/1ps
module tb_pwm_dual_out;
  localparam int unsigned CW = 6;
  localparam int unsigned RP = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_sel;
  logic [CW-1:0] wr_data;
  logic          pwm_a, pwm_b, period_start;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic [CW-1:0] s_per, s_duty, a_per, a_duty, m_cnt;
  logic          s_pol, s_mode, a_pol, a_mode, m_en, m_ph;

  always #2 clk = ~clk;

  pwm_dual_out #(.CW(CW), .RST_PERIOD(RP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .period_start(period_start)
  );

  task automatic model_reset();
    s_per = CW'(RP); s_duty = '0; s_pol = 1'b1; s_mode = 1'b0;
    a_per = CW'(RP); a_duty = '0; a_pol = 1'b1; a_mode = 1'b0;
    m_cnt = '0; m_en = 1'b0; m_ph = 1'b0;
  endtask

  task automatic model_edge(input logic we, input logic [2:0] sel,
                            input logic [CW-1:0] d);
    logic wrap;
    wrap = m_en && (m_cnt == a_per);
    if (!m_en || wrap) begin
      a_per = s_per; a_duty = s_duty; a_pol = s_pol; a_mode = s_mode;
    end
    if (!m_en) begin m_cnt = '0; m_ph = 1'b0; end
    else if (wrap) begin m_cnt = '0; m_ph = ~m_ph; end
    else m_cnt = m_cnt + 1'b1;
    if (we) begin
      case (sel)
        3'd0: s_per  = d;
        3'd1: s_duty = d;
        3'd2: s_pol  = d[0];
        3'd3: s_mode = d[0];
        3'd4: m_en   = d[0];
        default: ;
      endcase
    end
  endtask

  function automatic logic [2:0] expect_out();
    logic pulse, a, b, idle;
    pulse = (m_cnt < a_duty);
    idle  = ~a_pol;
    a = idle; b = idle;
    if (m_en) begin
      if (!a_mode) begin a = pulse ? a_pol : idle; b = ~a; end
      else begin
        a = (pulse && !m_ph) ? a_pol : idle;
        b = (pulse &&  m_ph) ? a_pol : idle;
      end
    end
    return {a, b, m_en && (m_cnt == '0)};
  endfunction

  task automatic compare(input string tag);
    logic [2:0] e;
    e = expect_out();
    n_vec++;
    if ({pwm_a, pwm_b} !== e[2:1]) begin
      n_bad++;
      $display("FAIL %s a/b got %b%b expected %b%b", tag, pwm_a, pwm_b, e[2], e[1]);
    end
    if (period_start !== e[0]) begin
      n_bad++;
      $display("FAIL R4 strobe (%s) got %b expected %b", tag, period_start, e[0]);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] sel,
                      input logic [CW-1:0] d, input string tag);
    wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    model_edge(we, sel, d);
    @(negedge clk);
    wr_en = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, tag);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    compare("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");

    // R10 / R2: complementary run
    step(1'b1, 3'd0, 6'd3, "R10");
    step(1'b1, 3'd1, 6'd2, "R10");
    step(1'b1, 3'd4, 6'd1, "R8");
    idle(16, "R2");
    // R3: push-pull, change lands at period end (R5)
    step(1'b1, 3'd3, 6'd1, "R5");
    idle(24, "R3");
    // R6: zero duty
    step(1'b1, 3'd1, 6'd0, "R5");
    idle(12, "R6");
    // R7: duty at and above period length
    step(1'b1, 3'd1, 6'd4, "R5");
    idle(12, "R7");
    step(1'b1, 3'd1, 6'd50, "R7");
    idle(12, "R7");
    // R9: active low
    step(1'b1, 3'd1, 6'd1, "R9");
    step(1'b1, 3'd2, 6'd0, "R9");
    idle(16, "R9");
    // R10: ignored selects
    step(1'b1, 3'd5, 6'h3f, "R10");
    step(1'b1, 3'd6, 6'h3f, "R10");
    step(1'b1, 3'd7, 6'h3f, "R10");
    idle(8, "R10");
    // R8: disable then re-enable mid-period
    idle(2, "R8");
    step(1'b1, 3'd4, 6'd0, "R8");
    idle(5, "R8");
    step(1'b1, 3'd4, 6'd1, "R8");
    idle(12, "R8");

    // random mix
    void'($urandom(32'd20240517));
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [2:0] sel;
      logic [CW-1:0] d;
      r = int'($urandom_range(0, 99));
      sel = 3'($urandom_range(0, 7));
      case (sel)
        3'd0: d = CW'($urandom_range(0, 9));
        3'd1: d = CW'($urandom_range(0, 20));
        3'd4: d = CW'(($urandom_range(0, 99) < 85) ? 1 : 0);
        default: d = CW'($urandom);
      endcase
      if (r < 12) step(1'b1, sel, d, a_mode ? "R3" : "R2");
      else        step(1'b0, 3'd0, '0, m_en ? (a_mode ? "R3" : "R2") : "R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule